// File: doc/BRIEF.md
# Periodic Output Impedance Calibrator

This block is the digital half of an output-driver impedance tracker. It holds two 6-bit drive-strength codes, one for the pull-down half of the driver (the half that drives zeros) and one for the pull-up half (the half that drives ones). An external reference measurement supplies one comparator result for each half. That result says whether the half is too weak, too strong or matched.

A free-running timer marks an evaluation edge once every 64 clock cycles. At that edge, each code may move one step toward its target. A code may move only while its half of the driver is idle. The pull-down code may change while the pins drive ones or float. The pull-up code may change while the pins drive zeros or float. If a code is blocked at the evaluation edge, its adjustment is dropped until the next evaluation.

A calibrated flag rises once at least 2048 cycles have passed since reset and both a zero and a one have been driven, in either order. The flag then stays high until the next reset.

Top module: `zq_cal_ctrl`

## Requirements
- R1: Evaluations happen on every 64th rising clock edge after reset release (edges 64, 128, ...). Neither code changes on any other edge.
- R2: Each comparator input is 2 bits: 2'b01 = too weak (code +1) and 2'b10 = too strong (code -1). At an evaluation a code moves by exactly one step in the indicated direction, or stays where it is.
- R3: While reset is held and right after it, both codes read 32 and the calibrated flag is low.
- R4: The pull-down code `pd_code_o` is updated only if the driver mode at the evaluation edge is 2'b10 (driving ones) or 2'b00 (high impedance).
- R5: The pull-up code `pu_code_o` is updated only if the driver mode at the evaluation edge is 2'b01 (driving zeros) or 2'b00 (high impedance).
- R6: Driver mode 2'b11 (both halves busy) blocks updates to both codes. It also does not count as having driven a zero or a one.
- R7: An adjustment blocked at an evaluation edge is dropped, not deferred. Only the driver mode at the evaluation edge itself decides whether a code is updated.
- R8: The codes saturate: an increment at 63 leaves 63, and a decrement at 0 leaves 0.
- R9: The calibrated flag `cal_ok_o` goes high only when both of these hold. First, at least 2048 clock edges have passed since reset release. Second, mode 2'b01 and mode 2'b10 have each been present at some edge. Once high, the flag stays high until reset.
- R10: Comparator values 2'b00 and 2'b11 mean hold, and leave the code unchanged at an evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_cmp_i | input | 2 | Pull-down comparator result (01 weak, 10 strong, else hold) |
| pu_cmp_i | input | 2 | Pull-up comparator result (01 weak, 10 strong, else hold) |
| drv_mode_i | input | 2 | Driver activity: 00 high-Z, 01 zeros, 10 ones, 11 both busy |
| pd_code_o | output | 6 | Pull-down strength code |
| pu_code_o | output | 6 | Pull-up strength code |
| cal_ok_o | output | 1 | Calibration valid |

## Verification
The hardest case to reach from the ports is a driver mode that changes exactly at the evaluation edge. The gating must follow the mode at that edge, not the mode that held for most of the interval. The stimulus counts edges from reset release. It holds a blocking mode for 63 cycles and then switches to a permitting mode for the single evaluation edge. It then checks that only the permitted code moved. Saturation is reached by holding one code's comparator at "too weak" and the other's at "too strong" for 33 intervals in high impedance. The calibrated-flag boundary is checked at edges 2047 and 2048, and also in a run where only ones were ever driven.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;
  typedef enum logic [1:0] {
    DRV_HIZ  = 2'b00,
    DRV_ZERO = 2'b01,
    DRV_ONE  = 2'b10,
    DRV_BOTH = 2'b11
  } drv_mode_e;

  typedef enum logic [1:0] {
    CMP_HOLD = 2'b00,
    CMP_UP   = 2'b01,
    CMP_DN   = 2'b10,
    CMP_HLD2 = 2'b11
  } cmp_e;

  localparam int unsigned HALF_PD = 0;
  localparam int unsigned HALF_PU = 1;
  localparam int unsigned N_HALF  = 2;
endpackage

// File: rtl/zq_eval_timer.sv
module zq_eval_timer #(
  parameter int unsigned PERIOD = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/zq_code_step.sv
module zq_code_step
  import zq_cal_pkg::*;
#(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned RESET_CODE = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              allow_i,
  input  logic [1:0]        cmp_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] code_q, code_d;
  cmp_e              cmp;

  assign cmp = cmp_e'(cmp_i);

  always_comb begin
    code_d = code_q;
    if (tick_i && allow_i) begin
      unique case (cmp)
        CMP_UP:  if (code_q != CODE_MAX) code_d = code_q + 1'b1;
        CMP_DN:  if (code_q != '0)       code_d = code_q - 1'b1;
        default: code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_RST;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/zq_warmup_mon.sv
module zq_warmup_mon
  import zq_cal_pkg::*;
#(
  parameter int unsigned WARMUP = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] drv_mode_i,
  output logic       ok_o
);
  localparam int unsigned WW = $clog2(WARMUP + 1);
  localparam logic [WW-1:0] WLIM = WW'(WARMUP);

  logic [WW-1:0] cnt_q;
  logic          seen_zero_q, seen_one_q;
  logic          warm_done;
  drv_mode_e     mode;

  assign mode      = drv_mode_e'(drv_mode_i);
  assign warm_done = (cnt_q == WLIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      seen_zero_q <= 1'b0;
      seen_one_q  <= 1'b0;
    end else begin
      if (!warm_done)        cnt_q       <= cnt_q + 1'b1;
      if (mode == DRV_ZERO)  seen_zero_q <= 1'b1;
      if (mode == DRV_ONE)   seen_one_q  <= 1'b1;
    end
  end

  assign ok_o = warm_done && seen_zero_q && seen_one_q;
endmodule

// File: rtl/zq_cal_ctrl.sv
module zq_cal_ctrl
  import zq_cal_pkg::*;
#(
  parameter int unsigned CODE_W      = 6,
  parameter int unsigned EVAL_PERIOD = 64,
  parameter int unsigned WARMUP      = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pd_cmp_i,
  input  logic [1:0]        pu_cmp_i,
  input  logic [1:0]        drv_mode_i,
  output logic [CODE_W-1:0] pd_code_o,
  output logic [CODE_W-1:0] pu_code_o,
  output logic              cal_ok_o
);
  localparam int unsigned MID_CODE = 1 << (CODE_W - 1);

  logic              eval_tick;
  drv_mode_e         mode;
  logic [1:0]        cmp   [N_HALF];
  logic              allow [N_HALF];
  logic [CODE_W-1:0] code  [N_HALF];

  assign mode = drv_mode_e'(drv_mode_i);

  // A half may be retuned only while it is not driving.
  assign allow[HALF_PD] = (mode == DRV_HIZ) || (mode == DRV_ONE);
  assign allow[HALF_PU] = (mode == DRV_HIZ) || (mode == DRV_ZERO);
  assign cmp[HALF_PD]   = pd_cmp_i;
  assign cmp[HALF_PU]   = pu_cmp_i;

  zq_eval_timer #(.PERIOD(EVAL_PERIOD)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (eval_tick)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    zq_code_step #(.CODE_W(CODE_W), .RESET_CODE(MID_CODE)) i_step (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (eval_tick),
      .allow_i (allow[h]),
      .cmp_i   (cmp[h]),
      .code_o  (code[h])
    );
  end

  zq_warmup_mon #(.WARMUP(WARMUP)) i_warm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drv_mode_i (drv_mode_i),
    .ok_o       (cal_ok_o)
  );

  assign pd_code_o = code[HALF_PD];
  assign pu_code_o = code[HALF_PU];
endmodule

// File: rtl/zq_cal_chk.sv
module zq_cal_chk #(
  parameter int unsigned CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        drv_mode_i,
  input logic              eval_tick,
  input logic [CODE_W-1:0] pd_code_o,
  input logic [CODE_W-1:0] pu_code_o,
  input logic              cal_ok_o
);
  localparam logic [CODE_W-1:0] CMAX = '1;

  a_r1_pd_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pd_code_o) |-> $past(eval_tick));
  a_r1_pu_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pu_code_o) |-> $past(eval_tick));
  a_r2_pd_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pd_code_o) |->
      ((pd_code_o == $past(pd_code_o) + 1'b1) || (pd_code_o == $past(pd_code_o) - 1'b1)));
  a_r2_pu_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pu_code_o) |->
      ((pu_code_o == $past(pu_code_o) + 1'b1) || (pu_code_o == $past(pu_code_o) - 1'b1)));
  a_r4_pd_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pd_code_o) |-> ($past(drv_mode_i) == 2'b00 || $past(drv_mode_i) == 2'b10));
  a_r5_pu_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pu_code_o) |-> ($past(drv_mode_i) == 2'b00 || $past(drv_mode_i) == 2'b01));
  a_r8_pd_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_code_o) == CMAX) |-> (pd_code_o != '0));
  a_r8_pu_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pu_code_o) == '0) |-> (pu_code_o != CMAX));
  a_r9_ok_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_ok_o |=> cal_ok_o);
endmodule

bind zq_cal_ctrl zq_cal_chk #(.CODE_W(CODE_W)) i_zq_cal_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .drv_mode_i (drv_mode_i),
  .eval_tick  (eval_tick),
  .pd_code_o  (pd_code_o),
  .pu_code_o  (pu_code_o),
  .cal_ok_o   (cal_ok_o)
);

// File: tb/test_zq_cal_ctrl.sv
module test_zq_cal_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam int PER = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] pd_cmp, pu_cmp, mode;
  logic [5:0] pd_code, pu_code;
  logic cal_ok;
  int total = 0, bad = 0, edges = 0;
  int exp_pd, exp_pu;

  always #(CLK_PERIOD/2) clk = ~clk;

  zq_cal_ctrl i_zq_cal_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pd_cmp_i(pd_cmp), .pu_cmp_i(pu_cmp),
    .drv_mode_i(mode), .pd_code_o(pd_code), .pu_code_o(pu_code), .cal_ok_o(cal_ok)
  );

  // {mode, pd_cmp, pu_cmp}
  localparam logic [5:0] VEC [NVEC] = '{
    {2'b00, 2'b01, 2'b01}, {2'b00, 2'b10, 2'b10}, {2'b10, 2'b01, 2'b01},
    {2'b01, 2'b01, 2'b01}, {2'b11, 2'b01, 2'b10}, {2'b00, 2'b00, 2'b11},
    {2'b10, 2'b10, 2'b10}, {2'b01, 2'b10, 2'b10}, {2'b00, 2'b01, 2'b10},
    {2'b10, 2'b11, 2'b01}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
    edges += n;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input int c, input logic [1:0] cmp, input bit allow);
    if (!allow) return c;
    if (cmp == 2'b01) return (c == 63) ? 63 : c + 1;
    if (cmp == 2'b10) return (c == 0) ? 0 : c - 1;
    return c;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    mode = 2'b00; pd_cmp = 2'b00; pu_cmp = 2'b00;
    step(3);
    chk("R3 pd reset", pd_code, 32);
    chk("R3 pu reset", pu_code, 32);
    chk("R3 ok reset", cal_ok, 0);
    @(negedge clk); rst_ni = 1'b1; #1;
    edges = 0; exp_pd = 32; exp_pu = 32;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // Table: one full interval per vector (R1 R2 R4 R5 R6 R10)
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] m;
      m = VEC[v][5:4];
      mode = m; pd_cmp = VEC[v][3:2]; pu_cmp = VEC[v][1:0];
      step(PER - 1);
      chk("R1 pd no early change", pd_code, exp_pd);
      chk("R1 pu no early change", pu_code, exp_pu);
      exp_pd = nxt(exp_pd, VEC[v][3:2], (m == 2'b00) || (m == 2'b10));
      exp_pu = nxt(exp_pu, VEC[v][1:0], (m == 2'b00) || (m == 2'b01));
      step(1);
      chk("R2/R4/R5/R6/R10 pd after eval", pd_code, exp_pd);
      chk("R2/R4/R5/R6/R10 pu after eval", pu_code, exp_pu);
    end
    // R7: mode at the eval edge decides; zeros all interval, ones at the edge
    mode = 2'b01; pd_cmp = 2'b01; pu_cmp = 2'b01;
    step(PER - 1);
    mode = 2'b10;
    step(1);
    chk("R7 pd updated by edge mode", pd_code, exp_pd + 1);
    chk("R7 pu skipped", pu_code, exp_pu);
    exp_pd = exp_pd + 1;
    mode = 2'b11;
    step(PER);
    chk("R7 pu skip not deferred", pu_code, exp_pu);
    // R9 warmup boundary: both values already seen
    step(2047 - edges);
    chk("R9 ok low at edge 2047", cal_ok, 0);
    step(1);
    chk("R9 ok high at edge 2048", cal_ok, 1);
    step(100);
    chk("R9 ok sticky", cal_ok, 1);

    // R8 saturation, and R9 needing both values
    do_reset();
    mode = 2'b00; pd_cmp = 2'b01; pu_cmp = 2'b10;
    step(PER * 33);
    chk("R8 pd saturates at 63", pd_code, 63);
    chk("R8 pu saturates at 0", pu_code, 0);
    chk("R9 ok low with no data driven", cal_ok, 0);
    mode = 2'b10; pd_cmp = 2'b00; pu_cmp = 2'b00;
    step(5);
    chk("R9 ok low with only ones", cal_ok, 0);
    mode = 2'b11;
    step(1);
    chk("R6 both-busy not counted as zero", cal_ok, 0);
    mode = 2'b01;
    step(1);
    chk("R9 ok high after zero seen", cal_ok, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule